// File: doc/BRIEF.md
# Multi-Mode Reloadable Pulse Timer

This block is one output-timer channel. It has a down counter, a reload register and a toggle output. Software writes the counter, the reload value and a control word that holds a mode and an enable bit. A rising edge on an external enable input can also start the channel. The counter moves only on cycles where the count strobe is high, so a prescaler outside the block sets the time base.

There are three modes:
- **Single-shot** gives one pulse of reload+1 counts, then stops.
- **Delayed single-shot** waits counter+1 counts, gives a pulse of reload+1 counts, then stops.
- **Continuous** gives a square wave whose half-period is reload+1 counts. It runs until software disables it.

On every underflow the channel raises a one-cycle interrupt request.

Top module: `reload_pulse_timer`

## Requirements
- R1: After reset, `tout` is 0, `irq` is 0, `cnt_value` is 0 and the channel is stopped.
- R2: A stopped channel starts in two ways: a control write with `ctl_en`=1, or a rising edge of `ext_en`. A start uses no count strobe, even if one is present in the start cycle. After the start, the counter moves only on cycles with `cnt_tick`=1.
- R3: The single-shot mode is `ctl_mode`=00.
  - At start it loads the counter from the reload register and toggles `tout`.
  - An underflow is a strobe while the counter is 0. On underflow it toggles `tout`, raises `irq` and stops. The counter wraps to all ones.
  - The pulse lasts reload+1 strobes.
- R4: The delayed mode is `ctl_mode`=01.
  - It starts from the counter's written value and does not toggle at start.
  - The first underflow toggles `tout`, raises `irq` and loads the reload value.
  - The second underflow toggles `tout`, raises `irq` and stops.
- R5: The continuous mode is `ctl_mode`=10 or 11.
  - It toggles `tout` at start and counts from the counter's written value.
  - Every underflow reloads the counter, toggles `tout` and raises `irq`.
  - It runs until a control write with `ctl_en`=0.
- R6: `irq` is high for the cycle after each underflow strobe, and only then.
- R7: While the channel runs, a control write with `ctl_en`=1 and a rising edge of `ext_en` are both ignored. This includes the mode field of that write.
- R8: A counter write takes effect only while the channel is stopped; while it runs, the write is ignored. A reload write always takes effect, and a running channel uses the new value at its next underflow.
- R9: A control write while stopped captures `ctl_mode`. This mode is also the one that a later `ext_en` start uses.
- R10: A control write with `ctl_en`=0 stops the channel in the next cycle. From then on, `tout` and `cnt_value` hold their values and no `irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Write `wdata` into the counter |
| rld_wr | input | 1 | Write `wdata` into the reload register |
| wdata | input | W | Write data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode: 00 single, 01 delayed, 1x continuous |
| ctl_en | input | 1 | Enable bit of the control write |
| ext_en | input | 1 | External start, active on its rising edge |
| cnt_tick | input | 1 | Count-clock strobe |
| cnt_value | output | W | Current counter value |
| tout | output | 1 | Toggle flip-flop output |
| irq | output | 1 | Underflow interrupt pulse |

## Verification
The bench builds the channel with W=4. At that width every reload and counter value fits in a short window. The bench sweeps all 16 reload values in single-shot mode. For the delayed and continuous modes it sweeps all 256 counter/reload pairs. In each run it compares `tout` and `irq` in every cycle against positions it computes from the counts. The narrow width also makes the wrap to all ones after an underflow easy to see. Directed runs cover the external-edge start, starts held off by missing strobes, starts ignored while running, a reload changed mid-run, counter writes while running, and stop.

// File: rtl/reload_pulse_timer.sv
module reload_pulse_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic         rld_wr,
  input  logic [W-1:0] wdata,
  input  logic         ctl_wr,
  input  logic [1:0]   ctl_mode,
  input  logic         ctl_en,
  input  logic         ext_en,
  input  logic         cnt_tick,
  output logic [W-1:0] cnt_value,
  output logic         tout,
  output logic         irq
);
  localparam logic [1:0] M_SINGLE = 2'b00;
  localparam logic [1:0] M_DELAY  = 2'b01;

  logic [W-1:0] cnt, rld;
  logic [1:0]   mode;
  logic         run, phase, ext_q, tout_q, irq_q;

  wire       ext_rise = ext_en & ~ext_q;
  wire       start    = !run && ((ctl_wr && ctl_en) || ext_rise);
  wire       stop     = run && ctl_wr && !ctl_en;
  wire       tick     = run && !stop && cnt_tick;
  wire       uf       = tick && (cnt == '0);
  wire [1:0] nmode    = (ctl_wr && !run) ? ctl_mode : mode;

  assign cnt_value = cnt;
  assign tout      = tout_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rld    <= '0;
      mode   <= M_SINGLE;
      run    <= 1'b0;
      phase  <= 1'b0;
      ext_q  <= 1'b0;
      tout_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ext_q <= ext_en;
      irq_q <= uf;
      if (rld_wr) rld <= wdata;
      if (ctl_wr && !run) mode <= ctl_mode;

      if (start) begin
        run   <= 1'b1;
        phase <= 1'b0;
        if (nmode != M_DELAY) tout_q <= ~tout_q;
        if (nmode == M_SINGLE) cnt <= rld;
        else if (cnt_wr)       cnt <= wdata;
      end else if (stop) begin
        run <= 1'b0;
      end else if (tick) begin
        if (uf) begin
          tout_q <= ~tout_q;
          if (mode == M_SINGLE || (mode == M_DELAY && phase)) begin
            run <= 1'b0;
            cnt <= cnt - 1'b1;
          end else begin
            cnt   <= rld;
            phase <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (!run && cnt_wr) begin
        cnt <= wdata;
      end
    end
  end
endmodule

// File: rtl/reload_pulse_timer_chk.sv
module reload_pulse_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic         cnt_wr,
  input logic         ctl_wr,
  input logic         ctl_en,
  input logic         ext_en,
  input logic [W-1:0] cnt_value,
  input logic         tout,
  input logic         irq,
  input logic         run
);
  assert_irq_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cnt_tick));

  assert_irq_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_value) == '0));

  assert_tout_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tout) |-> $past(cnt_tick || ctl_wr || ext_en));

  assert_cnt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_value) |-> $past(cnt_tick || cnt_wr || ctl_wr || ext_en));

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_en) |=> !run);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctl_wr && !ext_en) |=> $stable(tout));
endmodule

bind reload_pulse_timer reload_pulse_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_wr(cnt_wr),
  .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ext_en(ext_en), .cnt_value(cnt_value),
  .tout(tout), .irq(irq), .run(run)
);

// File: tb/sim_reload_pulse_timer.sv
module sim_reload_pulse_timer;
  localparam int W = 4;
  localparam int L = 36;

  logic clk = 0, rst_n = 0;
  logic cnt_wr = 0, rld_wr = 0, ctl_wr = 0, ctl_en = 0, ext_en = 0, cnt_tick = 0;
  logic [1:0] ctl_mode = 0;
  logic [W-1:0] wdata = 0;
  logic [W-1:0] cnt_value;
  logic tout, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  reload_pulse_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wdata(wdata),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_en(ctl_en), .ext_en(ext_en),
    .cnt_tick(cnt_tick), .cnt_value(cnt_value), .tout(tout), .irq(irq));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_i(int m, int c, int r, int k);
    if (m == 0) return k == r + 2;
    if (m == 1) return (k == c + 2) || (k == c + r + 3);
    return (k >= c + 2) && (((k - c - 2) % (r + 1)) == 0);
  endfunction

  function automatic bit exp_t(int m, int c, int r, int k);
    int n;
    if (m == 0) return k < r + 2;
    if (m == 1) return (k >= c + 2) && (k < c + r + 3);
    n = (k >= c + 2) ? (k - c - 2) / (r + 1) + 1 : 0;
    return ((1 + n) % 2) == 1;
  endfunction

  task automatic load(input int c, input int r);
    rld_wr = 1; wdata = W'(r); step(); rld_wr = 0;
    cnt_wr = 1; wdata = W'(c); step(); cnt_wr = 0;
  endtask

  task automatic halt();
    ctl_wr = 1; ctl_en = 0; step(); ctl_wr = 0; cnt_tick = 0; step();
  endtask

  task automatic run_mode(input int m, input int c, input int r, input string tag);
    bit base, bad;
    int ka, ke;
    load(c, r);
    base = tout; bad = 0; ka = 0; ke = 0;
    ctl_wr = 1; ctl_mode = 2'(m); ctl_en = 1; cnt_tick = 1; step(); ctl_wr = 0;
    for (int k = 1; k <= L; k++) begin
      if (!bad && ((tout !== (base ^ exp_t(m, c, r, k))) || (irq !== exp_i(m, c, r, k)))) begin
        bad = 1; ka = {tout, irq}; ke = {base ^ exp_t(m, c, r, k), exp_i(m, c, r, k)};
        $display("  mode %0d c %0d r %0d cycle %0d ({tout,irq})", m, c, r, k);
      end
      step();
    end
    chk(!bad, tag, ka, ke);
    if (m == 0) chk(cnt_value == '1, "R3 wrap", int'(cnt_value), (1 << W) - 1);
    halt();
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, nirq, first;
    logic [W-1:0] held;
    bit b;
    step(); step(); rst_n = 1; step();
    // R1 reset state
    chk(tout == 0 && irq == 0 && cnt_value == 0, "R1 reset", {tout, irq, cnt_value}, 0);

    for (int r = 0; r < 16; r++) run_mode(0, 0, r, "R3 single sweep");
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) run_mode(1, c, r, "R4 delayed sweep");
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) run_mode(2, c, r, "R5 continuous sweep");
    for (int r = 0; r < 4; r++) run_mode(3, 2, r, "R5 mode 11 continuous");

    // R2 start without ticks: loaded value held, tout toggled
    load(0, 5); b = tout;
    ctl_wr = 1; ctl_mode = 0; ctl_en = 1; step(); ctl_wr = 0;
    for (int i = 0; i < 5; i++) step();
    chk(cnt_value == 5 && tout == !b, "R2 no-tick hold", int'(cnt_value), 5);
    cnt_tick = 1; for (int i = 0; i < 8; i++) step();
    chk(tout == b, "R2 finish after ticks", tout, b);
    halt();

    // R9/R2 external start uses mode captured by a disabling control write
    load(0, 3); b = tout;
    ctl_wr = 1; ctl_mode = 0; ctl_en = 0; step(); ctl_wr = 0;
    ext_en = 1; cnt_tick = 1; step();
    hi = 0; nirq = 0;
    for (int i = 0; i < 12; i++) begin hi += (tout != b); nirq += irq; step(); end
    chk(hi == 4 && nirq == 1, "R9 ext start single", hi, 4);
    ext_en = 0; halt();

    // R7 starts while running ignored (ctl write with mode 10, and ext edge)
    load(0, 6); b = tout;
    ctl_wr = 1; ctl_mode = 0; ctl_en = 1; cnt_tick = 1; step(); ctl_wr = 0;
    hi = 0; nirq = 0;
    for (int i = 0; i < 20; i++) begin
      hi += (tout != b); nirq += irq;
      if (i == 2) begin ctl_wr = 1; ctl_mode = 2; ctl_en = 1; end
      else if (i == 3) begin ctl_wr = 0; ext_en = 1; end
      step();
    end
    chk(hi == 7 && nirq == 1, "R7 restart ignored", hi, 7);
    ext_en = 0; halt();

    // R8 reload write while running applies at next underflow
    load(2, 3);
    ctl_wr = 1; ctl_mode = 2; ctl_en = 1; cnt_tick = 1; step(); ctl_wr = 0;
    first = 0; nirq = 0;
    for (int k = 1; k <= 10; k++) begin
      if (k == 1) begin rld_wr = 1; wdata = 1; end else rld_wr = 0;
      if (irq) begin nirq++; if (!(k == 4 || k == 6 || k == 8 || k == 10)) first = k; end
      step();
    end
    chk(nirq == 4 && first == 0, "R8 reload mid-run", nirq, 4);

    // R8 counter write while running ignored
    cnt_tick = 0; step(); held = cnt_value;
    cnt_wr = 1; wdata = 4'd9; step(); cnt_wr = 0; step();
    chk(cnt_value == held, "R8 counter write ignored", int'(cnt_value), int'(held));

    // R10 stop freezes everything
    halt(); held = cnt_value; b = tout; cnt_tick = 1; nirq = 0; hi = 0;
    for (int i = 0; i < 10; i++) begin nirq += irq; hi += (tout != b) || (cnt_value != held); step(); end
    chk(nirq == 0 && hi == 0, "R10 stop", nirq + hi, 0);
    cnt_tick = 0;

    // R8 counter write while stopped takes effect
    cnt_wr = 1; wdata = 4'd11; step(); cnt_wr = 0;
    chk(cnt_value == 11, "R8 counter write stopped", int'(cnt_value), 11);

    // R6 irq lasts one cycle when underflows are spaced
    load(0, 2);
    ctl_wr = 1; ctl_mode = 0; ctl_en = 1; cnt_tick = 1; step(); ctl_wr = 0;
    nirq = 0; for (int i = 0; i < 10; i++) begin nirq += irq; step(); end
    chk(nirq == 1, "R6 single-cycle irq", nirq, 1);
    halt();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule